// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block runs read cycles against an external asynchronous memory or peripheral. A read request brings a word address. The block steps through three timed phases: setup, strobe and hold. Each phase lasts a programmable number of controller clock cycles. The block drives chip select, output enable, byte enables and the external address, and it captures the external data bus on the clock edge that closes the strobe phase. The device can stretch the strobe phase by raising a wait input, which the block passes through a two-flop synchronizer.

When the external bus is narrower than the 32-bit word, one request becomes a chain of narrow reads. The low address bits count up from zero, one step per narrow read. Chip select stays low for the whole chain, and each narrow read goes from hold straight back into setup with the timing that was latched for the word. The captured pieces are packed little-endian, so the first narrow read fills the least significant bits. The finished word appears on a one-cycle response pulse.

A request presented while the last hold cycle runs is taken at once. In that case the block passes through a programmable turnaround gap, with chip select high, before the next setup. Without such a request it returns to idle.

The request side is a valid/ready channel. A request is taken on a clock edge where both req_valid and req_ready are high, and it must hold its address until then. The response side has no back-pressure: rsp_valid is high for exactly one cycle and the consumer must take rsp_data in that cycle.

Top module: `async_rd_seq`

## Requirements
- R1: After reset, mem_cs_n and mem_oe_n are 1, every mem_be_n bit is 1, req_ready is 1 and rsp_valid is 0.
- R2: In the cycle after a request is accepted from idle, mem_cs_n goes to 0. Output enable then stays high for cfg_setup+1 cycles of setup.
- R3: mem_oe_n is 0 for exactly cfg_strobe+1 cycles when the synchronized wait is low. The data bus value present in the last of those cycles is the value captured.
- R4: mem_wait passes through two flops. While the synchronized wait is 1 in the final strobe cycle, the strobe phase is held and mem_oe_n stays 0.
- R5: After the strobe phase, mem_cs_n stays 0 and mem_oe_n stays 1 for cfg_hold+1 cycles.
- R6: A word takes WORD_W/BUS_W narrow reads. During narrow read k, mem_addr is {request address, k}, with k in the low bits. Chip select stays 0 from the first setup to the last hold, with no gap between the narrow reads.
- R7: Narrow read k fills rsp_data bits [k*BUS_W +: BUS_W]. rsp_valid is 1 for one cycle: the cycle right after the last hold cycle.
- R8: When no request is waiting at the end of the last hold cycle, mem_cs_n returns to 1 and req_ready is 1 in the following cycle.
- R9: req_ready is 1 during the last hold cycle of a word. A request accepted there causes cfg_turn+1 cycles with mem_cs_n at 1, followed directly by setup.
- R10: Setup, strobe and hold counts are taken from cfg_* only when a setup phase starts from idle or from turnaround. Changes made during a word have no effect until then.
- R11: All mem_be_n bits are 0 whenever mem_cs_n is 0, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | CNT_W | Setup length minus one |
| cfg_strobe | input | CNT_W | Strobe length minus one |
| cfg_hold | input | CNT_W | Hold length minus one |
| cfg_turn | input | CNT_W | Turnaround length minus one |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds a finished word |
| rsp_data | output | WORD_W | Assembled word |
| mem_cs_n | output | 1 | External chip select, active low |
| mem_oe_n | output | 1 | External output enable, active low |
| mem_be_n | output | BUS_W/8 | External byte enables, active low |
| mem_addr | output | MA_W | External address: word address with the narrow-read index in the low bits |
| mem_rdata | input | BUS_W | External data bus |
| mem_wait | input | 1 | Device wait request, asynchronous |

## Verification
A wrong phase counter or phase register first shows up as a chip select or output enable edge in the wrong cycle. The pin-level reference model flags it in that same cycle, without waiting for the word to complete. A wrong narrow-read index shows at once on the low bits of mem_addr while chip select is low. If it corrupts the packing instead, it shows in rsp_data at the end of the word. Wrongly latched timing shows as a wrong pulse width within one phase. A lost wait synchronizer stage shifts the strobe release by one cycle, which is detected on the next output-enable rise.

// File: rtl/arsq_pkg.sv
package arsq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

endpackage

// File: rtl/arsq_sync2.sv
module arsq_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/arsq_pack.sv
module arsq_pack #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [WORD_W-1:0] word
);
  localparam int NSUB = WORD_W / BUS_W;

  logic [BUS_W-1:0] slot_q [NSUB];

  for (genvar i = 0; i < NSUB; i++) begin : g_slot
    // little-endian: sub-read i lands in lane i
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (cap_en && (idx == IDX_W'(i)))
        slot_q[i] <= bus_data;
    end
    assign word[i*BUS_W +: BUS_W] = slot_q[i];
  end
endmodule

// File: rtl/arsq_fsm.sv
module arsq_fsm
  import arsq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int NSUB  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_strobe,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [CNT_W-1:0] cfg_turn,
  input  logic             wait_s,
  output logic             req_ready,
  output logic             accept,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx,
  output logic             cap_en,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSUB - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] su_q, st_q, ho_q, tu_q;
  logic [CNT_W-1:0] lim;
  logic             at_lim;
  logic             last_sub;
  logic             load_rd;
  logic             load_tu;

  always_comb begin
    unique case (ph_q)
      PH_SETUP:  lim = su_q;
      PH_STROBE: lim = st_q;
      PH_HOLD:   lim = ho_q;
      PH_TURN:   lim = tu_q;
      default:   lim = '0;
    endcase
  end

  assign at_lim    = (cnt_q == lim);
  assign last_sub  = (idx_q == LAST_IDX);
  assign done      = (ph_q == PH_HOLD) && at_lim && last_sub;
  assign req_ready = (ph_q == PH_IDLE) || done;
  assign accept    = req_valid && req_ready;
  assign cap_en    = (ph_q == PH_STROBE) && at_lim && !wait_s;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q + 1'b1;
    idx_d   = idx_q;
    load_rd = 1'b0;
    load_tu = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          ph_d    = PH_SETUP;
          idx_d   = '0;
          load_rd = 1'b1;
        end
      end
      PH_SETUP: begin
        if (at_lim) begin
          ph_d  = PH_STROBE;
          cnt_d = '0;
        end
      end
      PH_STROBE: begin
        if (at_lim) begin
          cnt_d = cnt_q;
          if (!wait_s) begin
            ph_d  = PH_HOLD;
            cnt_d = '0;
          end
        end
      end
      PH_HOLD: begin
        if (at_lim) begin
          cnt_d = '0;
          if (!last_sub) begin
            ph_d  = PH_SETUP;
            idx_d = idx_q + 1'b1;
          end else if (accept) begin
            ph_d    = PH_TURN;
            idx_d   = '0;
            load_tu = 1'b1;
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      PH_TURN: begin
        if (at_lim) begin
          ph_d    = PH_SETUP;
          cnt_d   = '0;
          load_rd = 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      su_q  <= '0;
      st_q  <= '0;
      ho_q  <= '0;
      tu_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      if (load_rd) begin
        su_q <= cfg_setup;
        st_q <= cfg_strobe;
        ho_q <= cfg_hold;
      end
      if (load_tu)
        tu_q <= cfg_turn;
    end
  end

  assign phase = ph_q;
  assign idx   = idx_q;
endmodule

// File: rtl/async_rd_seq.sv
module async_rd_seq
  import arsq_pkg::*;
#(
  parameter  int ADDR_W = 20,
  parameter  int BUS_W  = 8,
  parameter  int WORD_W = 32,
  parameter  int CNT_W  = 4,
  localparam int NSUB   = WORD_W / BUS_W,
  localparam int IDX_W  = (NSUB > 1) ? $clog2(NSUB) : 1,
  localparam int MA_W   = (NSUB > 1) ? ADDR_W + IDX_W : ADDR_W,
  localparam int BE_W   = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_turn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [MA_W-1:0]   mem_addr,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              mem_wait
);
  logic              wait_s;
  logic              accept;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              cap_en;
  logic              done;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] addr_q;
  logic              bus_act;

  arsq_sync2 u_wsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mem_wait),
    .q     (wait_s)
  );

  arsq_fsm #(
    .CNT_W (CNT_W),
    .NSUB  (NSUB),
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .cfg_turn   (cfg_turn),
    .wait_s     (wait_s),
    .req_ready  (req_ready),
    .accept     (accept),
    .phase      (phase),
    .idx        (idx),
    .cap_en     (cap_en),
    .done       (done)
  );

  arsq_pack #(
    .WORD_W (WORD_W),
    .BUS_W  (BUS_W),
    .IDX_W  (IDX_W)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .idx      (idx),
    .bus_data (mem_rdata),
    .word     (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (accept)
      addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done;
      if (done)
        rsp_data <= word;
    end
  end

  assign bus_act  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign mem_cs_n = !bus_act;
  assign mem_oe_n = (phase != PH_STROBE);
  assign mem_be_n = bus_act ? '0 : '1;

  if (NSUB > 1) begin : g_narrow
    assign mem_addr = {addr_q, idx};
  end else begin : g_full
    assign mem_addr = addr_q;
  end
endmodule

// File: rtl/arsq_checker.sv
module arsq_checker #(
  parameter int MA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_cs_n,
  input logic            mem_oe_n,
  input logic            rsp_valid,
  input logic [MA_W-1:0] mem_addr
);
  // R3: output enable only inside an active chip select
  a_r3_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);

  // R2: setup precedes strobe with chip select already low
  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_cs_n));

  // R5: hold follows strobe with chip select still low
  a_r5_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_cs_n);

  // R6: address steady across a strobe
  a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  // R7: response pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind async_rd_seq arsq_checker #(.MA_W(MA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr)
);

// File: tb/sim_async_rd_seq.sv
module sim_async_rd_seq;
  localparam int CLK_P = 10;
  localparam int AW    = 12;
  localparam int BW    = 8;
  localparam int WW    = 32;
  localparam int NS    = WW / BW;
  localparam int MAW   = AW + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_turn = '0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [AW-1:0]  req_addr = '0;
  logic           rsp_valid;
  logic [WW-1:0]  rsp_data;
  logic           mem_cs_n, mem_oe_n;
  logic [0:0]     mem_be_n;
  logic [MAW-1:0] mem_addr;
  logic [BW-1:0]  mem_rdata;
  logic           mem_wait = 1'b0;

  int checks = 0;
  int errs   = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] rd_fn(input logic [MAW-1:0] a);
    return (a[7:0] * 8'd13) ^ {2'b01, a[13:8]};
  endfunction

  assign mem_rdata = rd_fn(mem_addr);

  async_rd_seq #(.ADDR_W(AW), .BUS_W(BW), .WORD_W(WW), .CNT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model: phase 0 idle,1 setup,2 strobe,3 hold,4 turn
  int            m_ph, m_left, m_idx, m_su, m_st, m_ho;
  logic          m_w1, m_w2, m_rv;
  logic [AW-1:0] m_a;
  logic [WW-1:0] m_word, m_rd;

  function automatic bit exp_ready();
    return (m_ph == 0) || (m_ph == 3 && m_left == 1 && m_idx == NS - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_idx = 0; m_su = 0; m_st = 0; m_ho = 0;
      m_w1 = 0; m_w2 = 0; m_rv = 0; m_a = '0; m_word = '0; m_rd = '0;
    end else begin
      automatic bit w   = m_w2;
      automatic bit acc = req_valid && exp_ready();
      m_w2 = m_w1;
      m_w1 = mem_wait;
      m_rv = 1'b0;
      case (m_ph)
        0: if (acc) begin
             m_a = req_addr; m_su = cfg_setup; m_st = cfg_strobe; m_ho = cfg_hold;
             m_idx = 0; m_ph = 1; m_left = m_su + 1;
           end
        1: if (m_left == 1) begin m_ph = 2; m_left = m_st + 1; end else m_left--;
        2: if (m_left == 1) begin
             if (!w) begin
               m_word[m_idx*BW +: BW] = rd_fn({m_a, 2'(m_idx)});
               m_ph = 3; m_left = m_ho + 1;
             end
           end else m_left--;
        3: if (m_left == 1) begin
             if (m_idx < NS - 1) begin
               m_idx++; m_ph = 1; m_left = m_su + 1;
             end else begin
               m_rv = 1'b1; m_rd = m_word;
               if (acc) begin m_a = req_addr; m_ph = 4; m_left = cfg_turn + 1; end
               else m_ph = 0;
             end
           end else m_left--;
        default: if (m_left == 1) begin
             m_su = cfg_setup; m_st = cfg_strobe; m_ho = cfg_hold;
             m_idx = 0; m_ph = 1; m_left = m_su + 1;
           end else m_left--;
      endcase
    end
  end

  // ---------------- per-cycle comparison and pin monitors
  bit            cmp_on = 0;
  int            oe_run = 0, gap_run = 0, cs_run = 0, hi_run = 0;
  int            oe_lens[$];
  int            gaps[$];
  int            cs_len = 0, cs_gap = 0, max_oe = 0, n_rsp = 0;
  logic [WW-1:0] last_rsp;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      automatic bit ecs = !(m_ph >= 1 && m_ph <= 3);
      cmp("R2 mem_cs_n", 32'(mem_cs_n), 32'(ecs));
      cmp("R3 mem_oe_n", 32'(mem_oe_n), 32'(m_ph != 2));
      cmp("R11 mem_be_n", 32'(mem_be_n), 32'(ecs));
      cmp("R9 req_ready", 32'(req_ready), 32'(exp_ready()));
      cmp("R7 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (!ecs) cmp("R6 mem_addr", 32'(mem_addr), 32'({m_a, 2'(m_idx)}));
      if (m_rv) cmp("R7 rsp_data", rsp_data, m_rd);
    end
    if (rst_n) begin
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        oe_lens.push_back(oe_run);
        if (oe_run > max_oe) max_oe = oe_run;
        oe_run = 0;
      end
      if (!mem_cs_n && mem_oe_n) gap_run++;
      else if (!mem_oe_n && gap_run > 0) begin gaps.push_back(gap_run); gap_run = 0; end
      else gap_run = 0;
      if (!mem_cs_n) begin
        if (hi_run > 0) begin cs_gap = hi_run; hi_run = 0; end
        cs_run++;
      end else begin
        if (cs_run > 0) begin cs_len = cs_run; cs_run = 0; end
        hi_run++;
      end
      if (rsp_valid) begin n_rsp++; last_rsp = rsp_data; end
    end
  end

  task automatic send(input logic [AW-1:0] a);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    while (n_rsp < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input int su, input int st, input int ho, input int tu);
    cfg_setup = 4'(su); cfg_strobe = 4'(st); cfg_hold = 4'(ho); cfg_turn = 4'(tu);
  endtask

  function automatic logic [WW-1:0] exp_word(input logic [AW-1:0] a);
    logic [WW-1:0] w;
    for (int i = 0; i < NS; i++) w[i*BW +: BW] = rd_fn({a, 2'(i)});
    return w;
  endfunction

  task automatic clear_mon();
    oe_lens.delete(); gaps.delete(); max_oe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R8 watchdog expired, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1 cs_n reset", 32'(mem_cs_n), 32'd1);
    cmp("R1 oe_n reset", 32'(mem_oe_n), 32'd1);
    cmp("R1 be_n reset", 32'(mem_be_n), 32'd1);
    cmp("R1 ready reset", 32'(req_ready), 32'd1);
    cmp("R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);

    // 2/3/2 cycle phases on a byte bus
    set_cfg(1, 2, 1, 2);
    clear_mon();
    send(12'h123);
    wait_rsp(1);
    cmp("R2 setup length", 32'(gaps[0]), 32'd2);
    cmp("R3 strobe length", 32'(oe_lens[0]), 32'd3);
    cmp("R5 hold+setup gap", 32'(gaps[1]), 32'd4);
    cmp("R6 chained cs low length", 32'(cs_len), 32'd28);
    cmp("R7 packed word", last_rsp, exp_word(12'h123));
    cmp("R8 idle cs_n", 32'(mem_cs_n), 32'd1);
    cmp("R8 idle ready", 32'(req_ready), 32'd1);

    // minimum timing
    set_cfg(0, 0, 0, 0);
    clear_mon();
    send(12'hA5C);
    wait_rsp(2);
    cmp("R3 minimum strobe", 32'(oe_lens[0]), 32'd1);
    cmp("R6 minimum chain length", 32'(cs_len), 32'd12);
    cmp("R7 packed word min", last_rsp, exp_word(12'hA5C));

    // wait stretches strobe
    set_cfg(1, 2, 1, 0);
    clear_mon();
    mem_wait = 1'b1;
    send(12'h0F0);
    repeat (10) @(negedge clk);
    mem_wait = 1'b0;
    wait_rsp(3);
    cmp("R4 strobe stretched", 32'(max_oe > 3), 32'd1);
    cmp("R4 later strobes normal", 32'(oe_lens[NS-1]), 32'd3);
    cmp("R7 packed word wait", last_rsp, exp_word(12'h0F0));

    // pending request, cfg changed mid-word
    set_cfg(1, 2, 1, 0);
    clear_mon();
    send(12'h3C3);
    set_cfg(0, 0, 0, 2);
    send(12'h777);
    wait_rsp(5);
    cmp("R10 first word keeps strobe", 32'(oe_lens[NS-1]), 32'd3);
    cmp("R10 second word new strobe", 32'(oe_lens[NS]), 32'd1);
    cmp("R9 turnaround gap", 32'(cs_gap), 32'd3);
    cmp("R7 second word", last_rsp, exp_word(12'h777));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule